// File: doc/BRIEF.md
# Test Pattern Video Generator

This block produces the drive bits for a set of TV alignment patterns. It works them out directly from the current scan position instead of reading them from a stored image. A scan counter elsewhere supplies the line number (1 to 312), the location within the line (1 to 210) and a blanking flag. The block returns three active-low gun bits for red, green and blue. The outputs are registered, so they lag the position inputs by one clock.

Five patterns are available. Checkerboard, dot grid and crosshatch are monochrome. The crosshatch carries an ellipse overlay, which shows as a true circle on a 4:3 screen. A full raster comes in two forms, red only and white. A colour-bar override replaces whichever pattern is selected with eight bars. The grid lines are placed so that a row and a column cross exactly at screen centre, at line 167 and location 125. The outer two colour bars are wider than the rest, to allow for overscan.

Top module: `test_pattern_gen`

## Requirements
- R1: While rst_n is low the three outputs are high. After reset, each output value depends only on the inputs sampled one clock earlier.
- R2: All three outputs are high when blank was set. They are also high when the location was below 41 or above 210. Locations 41 to 210 are the visible span.
- R3: Each output reflects the inputs presented at the previous rising clock edge, with exactly one cycle of latency.
- R4: Pattern select codes are: 0 checkerboard, 1 dot grid, 2 crosshatch with ellipse, 3 red raster, 4 white raster. On a visible location, the red raster gives {red_n,grn_n,blu_n}=011 and the white raster gives 000.
- R5: When bars_en is high it overrides pat_sel. The bars run left to right as white, yellow, cyan, green, magenta, red, blue, black. The active-low values of {red_n,grn_n,blu_n} are 000, 001, 100, 101, 010, 011, 110, 111.
- R6: The first bar covers locations 41 to 64 (24 wide). The six middle bars are 20 wide, starting at 65, 85, 105, 125, 145 and 165. The black bar covers 185 to 210.
- R7: A crosshatch column is lit on every location 41+12k, for k from 0 to 14. This puts the centre column at 125.
- R8: Crosshatch rows are full-width and lie on lines 30, 57, 85, 112, 140, 167, 194, 222, 249, 277 and 304.
- R9: The dot pattern is lit only where a row line of R8 meets a column location of R7.
- R10: In crosshatch mode a location is also lit when it lies on the ellipse, using dx=location−125 and dy=line−167. The test is |dx²·114² + dy²·50² − 50²·114²| ≤ max(|dx|·114², |dy|·50²).
- R11: The checkerboard has columns of 24 locations starting at 41, with the last column extending to 210. Its rows are 57 lines tall starting at line 24, with rows before 24 counting as row 0 and the fifth row extending to the end. A square is lit (000) when its column index plus row index is even, and dark (111) otherwise.
- R12: Select codes 5, 6 and 7 without bars_en give all outputs high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Location clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_idx | input | 9 | Current line, 1 to 312 |
| loc_idx | input | 8 | Current location in the line, 1 to 210 |
| blank | input | 1 | Blanking flag, forces outputs inactive |
| pat_sel | input | 3 | Pattern select code |
| bars_en | input | 1 | Colour-bar override |
| red_n | output | 1 | Red gun drive, active low |
| grn_n | output | 1 | Green gun drive, active low |
| blu_n | output | 1 | Blue gun drive, active low |

## Verification
Each pattern is probed on the exact boundary locations and lines, and on the neighbour just past each one. This separates an off-by-one in the column pitch, the row table or a bar edge from correct geometry. The ellipse is tested off the grid at two adjacent locations, one inside the band and one just outside, so a band that is too wide or too thin shows up. The same point is also tested in dot mode, to confirm the overlay belongs to the crosshatch only. Colour bars are driven with a raster selected underneath, which shows whether the override wins. Back-to-back items that alternate blanking and content expose any change in latency.

// File: rtl/test_pattern_gen.sv
module test_pattern_gen #(
  parameter int LINE_W    = 9,
  parameter int LOC_W     = 8,
  parameter int FIRST_VIS = 41,
  parameter int LAST_LOC  = 210,
  parameter int CX        = 125,
  parameter int CY        = 167,
  parameter int RX        = 50,
  parameter int RY        = 114,
  parameter int COL_PITCH = 12,
  parameter int COLS      = 15,
  parameter int ROWS      = 11,
  parameter int ROW0      = 30,
  parameter int ROW_PITCH = 27,
  parameter int CHK_W     = 24,
  parameter int CHK_H     = 57,
  parameter int CHK_TOP   = 24,
  parameter int CHK_COLS  = 7,
  parameter int CHK_ROWS  = 5,
  parameter int BAR_OUTER = 24,
  parameter int BAR_INNER = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINE_W-1:0] line_idx,
  input  logic [LOC_W-1:0]  loc_idx,
  input  logic              blank,
  input  logic [2:0]        pat_sel,
  input  logic              bars_en,
  output logic              red_n,
  output logic              grn_n,
  output logic              blu_n
);
  localparam int HALF     = ROWS / 2;
  localparam int LAST_COL = FIRST_VIS + (COLS - 1) * COL_PITCH;
  localparam int RX2      = RX * RX;
  localparam int RY2      = RY * RY;
  localparam int R2PROD   = RX2 * RY2;

  function automatic int row_pos(int k);
    int m, p;
    m = (k <= HALF) ? k : ROWS - 1 - k;
    p = ROW0 + m * ROW_PITCH + m / 2;
    return (k <= HALF) ? p : 2 * CY - p;
  endfunction

  int ln, lc;
  assign ln = int'(line_idx);
  assign lc = int'(loc_idx);

  logic vis;
  assign vis = !blank && lc >= FIRST_VIS && lc <= LAST_LOC;

  // grid lines
  logic [ROWS-1:0] row_hit;
  for (genvar k = 0; k < ROWS; k++) begin : g_row
    assign row_hit[k] = (ln == row_pos(k));
  end
  logic on_row, on_col;
  assign on_row = |row_hit;
  assign on_col = lc >= FIRST_VIS && lc <= LAST_COL && ((lc - FIRST_VIS) % COL_PITCH) == 0;

  // ellipse band by cross-multiplication
  int dx, dy, adx, ady, f, af, thx, thy, thr;
  assign dx  = lc - CX;
  assign dy  = ln - CY;
  assign adx = (dx < 0) ? -dx : dx;
  assign ady = (dy < 0) ? -dy : dy;
  assign f   = dx * dx * RY2 + dy * dy * RX2 - R2PROD;
  assign af  = (f < 0) ? -f : f;
  assign thx = adx * RY2;
  assign thy = ady * RX2;
  assign thr = (thx > thy) ? thx : thy;
  logic on_ell;
  assign on_ell = af <= thr;

  // checkerboard
  int ccol, crow, crow_raw;
  assign ccol     = ((lc - FIRST_VIS) / CHK_W > CHK_COLS - 1) ? CHK_COLS - 1 : (lc - FIRST_VIS) / CHK_W;
  assign crow_raw = (ln < CHK_TOP) ? 0 : (ln - CHK_TOP) / CHK_H;
  assign crow     = (crow_raw > CHK_ROWS - 1) ? CHK_ROWS - 1 : crow_raw;
  logic chk_lit;
  assign chk_lit = ((ccol + crow) % 2) == 0;

  // colour bars
  int bar_raw;
  assign bar_raw = (lc < FIRST_VIS + BAR_OUTER) ? 0 : 1 + (lc - FIRST_VIS - BAR_OUTER) / BAR_INNER;
  logic [2:0] bar;
  assign bar = (bar_raw > 7) ? 3'd7 : 3'(bar_raw);

  logic [2:0] rgb_d;
  always_comb begin
    if (!vis)        rgb_d = 3'b111;
    else if (bars_en) rgb_d = {bar[1], bar[2], bar[0]};
    else begin
      case (pat_sel)
        3'd0:    rgb_d = {3{~chk_lit}};
        3'd1:    rgb_d = {3{~(on_row & on_col)}};
        3'd2:    rgb_d = {3{~(on_row | on_col | on_ell)}};
        3'd3:    rgb_d = 3'b011;
        3'd4:    rgb_d = 3'b000;
        default: rgb_d = 3'b111;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) {red_n, grn_n, blu_n} <= 3'b111;
    else        {red_n, grn_n, blu_n} <= rgb_d;
  end
endmodule

// File: rtl/test_pattern_gen_checker.sv
module test_pattern_gen_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       blank,
  input logic [7:0] loc_idx,
  input logic [2:0] pat_sel,
  input logic       bars_en,
  input logic       red_n,
  input logic       grn_n,
  input logic       blu_n
);
  logic vis;
  assign vis = !blank && loc_idx >= 8'd41 && loc_idx <= 8'd210;

  AST_BLANK_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    !vis |=> (red_n && grn_n && blu_n)); // R2
  AST_RED_RASTER: assert property (@(posedge clk) disable iff (!rst_n)
    (vis && !bars_en && pat_sel == 3'd3) |=> (!red_n && grn_n && blu_n)); // R4
  AST_FIRST_BAR_WHITE: assert property (@(posedge clk) disable iff (!rst_n)
    (vis && bars_en && loc_idx <= 8'd64) |=> (!red_n && !grn_n && !blu_n)); // R6
  AST_MONO_DOT: assert property (@(posedge clk) disable iff (!rst_n)
    (!bars_en && pat_sel == 3'd1) |=> (red_n == grn_n && grn_n == blu_n)); // R9
  AST_UNUSED_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    (!bars_en && pat_sel >= 3'd5) |=> (red_n && grn_n && blu_n)); // R12
  AST_BLACK_BAR: assert property (@(posedge clk) disable iff (!rst_n)
    (bars_en && loc_idx >= 8'd185) |=> (red_n && grn_n && blu_n)); // R5
endmodule

bind test_pattern_gen test_pattern_gen_checker chk_i (
  .clk(clk), .rst_n(rst_n), .blank(blank), .loc_idx(loc_idx),
  .pat_sel(pat_sel), .bars_en(bars_en),
  .red_n(red_n), .grn_n(grn_n), .blu_n(blu_n)
);

// File: tb/test_pattern_gen_tb_top.sv
module test_pattern_gen_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [8:0] line_idx = '0;
  logic [7:0] loc_idx = '0;
  logic blank = 1'b0;
  logic [2:0] pat_sel = '0;
  logic bars_en = 1'b0;
  logic red_n, grn_n, blu_n;

  always #10 clk = ~clk;

  test_pattern_gen dut_i (
    .clk(clk), .rst_n(rst_n), .line_idx(line_idx), .loc_idx(loc_idx),
    .blank(blank), .pat_sel(pat_sel), .bars_en(bars_en),
    .red_n(red_n), .grn_n(grn_n), .blu_n(blu_n)
  );

  typedef struct { logic [2:0] exp; string tag; } item_t;
  item_t q[$];
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  task automatic check(input logic [2:0] act, input logic [2:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: rgb_n actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic drive(input int ln, input int lc, input bit bk, input int sel,
                       input bit br, input logic [2:0] exp, input string tag);
    item_t it;
    @(negedge clk);
    line_idx = 9'(ln); loc_idx = 8'(lc); blank = bk; pat_sel = 3'(sel); bars_en = br;
    it.exp = exp; it.tag = tag;
    q.push_back(it);
  endtask

  // monitor: results appear one clock after the driving negedge (R3)
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (rst_n && q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        check({red_n, grn_n, blu_n}, it.exp, it.tag);
      end
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL R3: watchdog expired actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    line_idx = 9'd100; loc_idx = 8'd100; pat_sel = 3'd4;
    repeat (3) @(negedge clk);
    check({red_n, grn_n, blu_n}, 3'b111, "R1 reset");
    rst_n = 1'b1;

    // raster and visibility
    drive(100, 41, 0, 4, 0, 3'b000, "R4 white raster");
    drive(100, 40, 0, 4, 0, 3'b111, "R2 loc 40");
    drive(100, 210, 0, 4, 0, 3'b000, "R4 loc 210");
    drive(100, 150, 1, 4, 0, 3'b111, "R2 blank");
    drive(100, 150, 0, 3, 0, 3'b011, "R4 red raster");
    drive(100, 150, 1, 3, 0, 3'b111, "R3 alternate blank");
    drive(100, 150, 0, 4, 0, 3'b000, "R3 alternate white");

    // colour bars over red raster
    drive(100, 41, 0, 3, 1, 3'b000, "R5 white bar");
    drive(100, 64, 0, 3, 1, 3'b000, "R6 outer bar end");
    drive(100, 65, 0, 3, 1, 3'b001, "R6 yellow start");
    drive(100, 84, 0, 3, 1, 3'b001, "R6 yellow end");
    drive(100, 85, 0, 3, 1, 3'b100, "R5 cyan");
    drive(100, 105, 0, 3, 1, 3'b101, "R5 green");
    drive(100, 125, 0, 3, 1, 3'b010, "R5 magenta");
    drive(100, 145, 0, 3, 1, 3'b011, "R5 red");
    drive(100, 165, 0, 3, 1, 3'b110, "R5 blue");
    drive(100, 184, 0, 3, 1, 3'b110, "R6 blue end");
    drive(100, 185, 0, 3, 1, 3'b111, "R6 black start");
    drive(100, 210, 0, 4, 1, 3'b111, "R6 black end");
    drive(100, 100, 1, 4, 1, 3'b111, "R2 blank bars");

    // crosshatch columns and rows
    drive(100, 41, 0, 2, 0, 3'b000, "R7 col 41");
    drive(100, 125, 0, 2, 0, 3'b000, "R7 col 125");
    drive(100, 209, 0, 2, 0, 3'b000, "R7 col 209");
    drive(100, 42, 0, 2, 0, 3'b111, "R7 loc 42");
    drive(100, 210, 0, 2, 0, 3'b111, "R7 loc 210");
    drive(100, 100, 0, 2, 0, 3'b111, "R8 empty");
    drive(57, 100, 0, 2, 0, 3'b000, "R8 row 57");
    drive(194, 100, 0, 2, 0, 3'b000, "R8 row 194");
    drive(195, 100, 0, 2, 0, 3'b111, "R8 line 195");
    drive(304, 60, 0, 2, 0, 3'b000, "R8 row 304");
    drive(29, 100, 0, 2, 0, 3'b111, "R8 line 29");

    // ellipse
    drive(170, 175, 0, 2, 0, 3'b000, "R10 on band");
    drive(170, 174, 0, 2, 0, 3'b111, "R10 inside band");
    drive(53, 126, 0, 2, 0, 3'b000, "R10 top");

    // dot grid
    drive(167, 125, 0, 1, 0, 3'b000, "R9 centre dot");
    drive(167, 126, 0, 1, 0, 3'b111, "R9 row only");
    drive(100, 125, 0, 1, 0, 3'b111, "R9 column only");
    drive(170, 175, 0, 1, 0, 3'b111, "R9 no ellipse");
    drive(30, 41, 0, 1, 0, 3'b000, "R9 corner dot");

    // checkerboard
    drive(24, 41, 0, 0, 0, 3'b000, "R11 first square");
    drive(24, 64, 0, 0, 0, 3'b000, "R11 first square end");
    drive(24, 65, 0, 0, 0, 3'b111, "R11 second column");
    drive(80, 41, 0, 0, 0, 3'b000, "R11 row0 end");
    drive(81, 41, 0, 0, 0, 3'b111, "R11 row1");
    drive(81, 65, 0, 0, 0, 3'b000, "R11 row1 col1");
    drive(310, 210, 0, 0, 0, 3'b000, "R11 last corner");

    // unused selects
    drive(100, 100, 0, 5, 0, 3'b111, "R12 sel 5");
    drive(100, 100, 0, 7, 0, 3'b111, "R12 sel 7");

    @(negedge clk);
    blank = 1'b1;
    repeat (3) @(negedge clk);
    done = 1'b1;
    if (q.size() != 0) begin
      errors++; checks++;
      $display("FAIL R3: pending actual=%0d expected=0", q.size());
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule